// File: doc/BRIEF.md
# Dual-Converter Input Channel Selector

This block decides which analog input each of two converters samples in its next conversion, and it tags every finished result with the input it came from. A mode pin picks one of two policies. When the pin is low, software chooses: a 2-bit configuration field gives one select bit to each converter. When the pin is high, the block advances the selection by itself. Fully-differential inputs alternate between input 0 and input 1 of each converter. Pseudo-differential inputs are handed to an internal sequencer that walks inputs 0, 1, 2 and 3 in turn.

The selection is register-held and changes only on the end-of-conversion pulse, so a conversion always completes on the input it started with. The same pulse captures the selection that was just used as the result tag. Two configuration-derived flags leave the block combinationally. The first is the effective channel-ID enable, which is forced on for pseudo-differential automatic operation. The second is a buffering-available flag, which is held low in manual mode. The configuration register is modelled as plain inputs.

Top module: `chsel_top`

## Requirements
- R1: After reset, both multiplexer selects and both result tags are 0, and the internal sequencer points at input 0.
- R2: In manual mode (`auto_mode_i` = 0), each `eoc_i` pulse loads converter A's select (`mux_sel_o[1:0]`) with `chan_field_i[0]` and converter B's select (`mux_sel_o[3:2]`) with `chan_field_i[1]`. The upper select bit is 0 in both cases.
- R3: In manual mode, a change of `chan_field_i` while `eoc_i` is low leaves the selects unchanged.
- R4: In automatic mode with `pseudo_diff_i` = 0, each `eoc_i` pulse sets each select to 1 if its previous bit 0 was 0, and to 0 otherwise. `chan_field_i` has no effect in this mode.
- R5: In automatic mode with `pseudo_diff_i` = 1, each `eoc_i` pulse loads both selects with the sequencer value, and the sequencer then steps 0, 1, 2, 3 and wraps to 0.
- R6: The sequencer advances only on pulses taken in pseudo-differential automatic mode. It keeps its position through pulses taken in other modes and resumes from that position.
- R7: On each `eoc_i` pulse, `tag_o` takes the select values that were in force before the pulse, with the same field positions as `mux_sel_o`.
- R8: `cid_en_o` equals `cid_cfg_i`, except that it is 1 whenever `auto_mode_i` and `pseudo_diff_i` are both 1.
- R9: `fifo_avail_o` is 0 in manual mode and equals `fifo_cfg_i` in automatic mode.
- R10: In every mode, the selects and tags hold their values in all cycles in which `eoc_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| eoc_i | input | 1 | End-of-conversion pulse, one cycle wide |
| auto_mode_i | input | 1 | Mode pin: 0 selects manual, 1 selects automatic |
| chan_field_i | input | 2 | Manual select field: bit 0 is for converter A, bit 1 is for converter B |
| pseudo_diff_i | input | 1 | Pseudo-differential input enable |
| cid_cfg_i | input | 1 | Configured channel-ID enable |
| fifo_cfg_i | input | 1 | Configured buffering request |
| mux_sel_o | output | 4 | Input select: converter A in [1:0], converter B in [3:2] |
| tag_o | output | 4 | Channel tag of the last finished result, with the same layout |
| cid_en_o | output | 1 | Effective channel-ID enable |
| fifo_avail_o | output | 1 | Buffering available |

## Verification
The assertions take for granted that `eoc_i` is synchronous to `clk_i` and that the mode and configuration inputs are settled at the clock edge that samples a pulse. The stimulus meets this by changing every input only on falling clock edges. It raises `eoc_i` for exactly one cycle at a time. It changes the mode or the field only between pulses, never in the cycle of a pulse.

// File: rtl/chsel_pkg.sv
package chsel_pkg;

  // Selection policy in force for the next end-of-conversion pulse
  typedef enum logic [1:0] {
    MODE_MANUAL = 2'd0,   // register field drives the select
    MODE_ALT    = 2'd1,   // fully-differential alternation
    MODE_SEQ    = 2'd2    // pseudo-differential sequencer
  } chsel_mode_e;

  // Next select for the alternation policy: flip bit 0, clear the rest
  function automatic logic [7:0] alt_next(input logic [7:0] cur);
    logic [7:0] nxt;
    nxt    = '0;
    nxt[0] = ~cur[0];
    return nxt;
  endfunction

endpackage

// File: rtl/chsel_rst_sync.sv
module chsel_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/chsel_mode_decode.sv
module chsel_mode_decode
  import chsel_pkg::*;
(
  input  logic        auto_mode_i,
  input  logic        pseudo_diff_i,
  input  logic        cid_cfg_i,
  input  logic        fifo_cfg_i,
  output chsel_mode_e mode_o,
  output logic        cid_en_o,
  output logic        fifo_avail_o
);

  logic seq_owned;

  always_comb begin
    seq_owned = auto_mode_i & pseudo_diff_i;

    if (!auto_mode_i) begin
      mode_o = MODE_MANUAL;
    end else if (pseudo_diff_i) begin
      mode_o = MODE_SEQ;
    end else begin
      mode_o = MODE_ALT;
    end

    // Pseudo-differential automatic operation always carries the ID
    cid_en_o     = cid_cfg_i | seq_owned;
    // Buffering is never offered under manual selection
    fifo_avail_o = auto_mode_i & fifo_cfg_i;
  end

endmodule

// File: rtl/chsel_pd_sequencer.sv
module chsel_pd_sequencer
  import chsel_pkg::*;
#(
  parameter int unsigned SEQ_LEN = 4,
  localparam int unsigned SEL_W  = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoc_i,
  input  chsel_mode_e      mode_i,
  output logic [SEL_W-1:0] seq_val_o
);

  localparam logic [SEL_W-1:0] LAST = SEL_W'(SEQ_LEN - 1);

  logic [SEL_W-1:0] ptr_q;
  logic [SEL_W-1:0] ptr_d;
  logic             step_en;

  always_comb begin
    step_en = eoc_i && (mode_i == MODE_SEQ);
    ptr_d   = ptr_q;
    if (step_en) begin
      if (ptr_q == LAST) begin
        ptr_d = '0;
      end else begin
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (step_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign seq_val_o = ptr_q;

  // R5: the pointer never leaves the sequence range
  assert_seq_in_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST);

  // R5: every pulse in sequencer mode moves the pointer
  assert_seq_moves_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && mode_i == MODE_SEQ) |=> (ptr_q != $past(ptr_q)));

  // R6: the pointer holds on any pulse outside sequencer mode
  assert_seq_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(eoc_i && mode_i == MODE_SEQ) |=> $stable(ptr_q));

endmodule

// File: rtl/chsel_lane.sv
module chsel_lane
  import chsel_pkg::*;
#(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             eoc_i,
  input  chsel_mode_e      mode_i,
  input  logic             man_bit_i,
  input  logic [SEL_W-1:0] seq_val_i,
  output logic [SEL_W-1:0] sel_o,
  output logic [SEL_W-1:0] tag_o
);

  logic [SEL_W-1:0] sel_q;
  logic [SEL_W-1:0] sel_d;
  logic [SEL_W-1:0] tag_q;
  logic [SEL_W-1:0] tag_d;
  logic [7:0]       alt_wide;

  always_comb begin
    alt_wide = alt_next(8'(sel_q));
    tag_d    = sel_q;
    unique case (mode_i)
      MODE_MANUAL: sel_d = SEL_W'(man_bit_i);
      MODE_ALT:    sel_d = alt_wide[SEL_W-1:0];
      MODE_SEQ:    sel_d = seq_val_i;
      default:     sel_d = sel_q;
    endcase
  end

  // Both registers only load on the end-of-conversion enable
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
      tag_q <= '0;
    end else if (eoc_i) begin
      sel_q <= sel_d;
      tag_q <= tag_d;
    end
  end

  assign sel_o = sel_q;
  assign tag_o = tag_q;

  // R2: manual pulse loads the field bit
  assert_manual_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && mode_i == MODE_MANUAL) |=> (sel_q == SEL_W'($past(man_bit_i))));

  // R4: alternation flips bit 0 on every pulse
  assert_alt_flips_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && mode_i == MODE_ALT) |=> (sel_q[0] != $past(sel_q[0])));

  // R5: sequencer pulse copies the sequencer value
  assert_seq_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoc_i && mode_i == MODE_SEQ) |=> (sel_q == $past(seq_val_i)));

  // R7: tag takes the selection used by the finished conversion
  assert_tag_follows_sel_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoc_i |=> (tag_q == $past(sel_q)));

  // R10: nothing moves between pulses
  assert_hold_between_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eoc_i |=> ($stable(sel_q) && $stable(tag_q)));

endmodule

// File: rtl/chsel_top.sv
module chsel_top
  import chsel_pkg::*;
#(
  parameter int unsigned NUM_CONV = 2,
  parameter int unsigned SEQ_LEN  = 4,
  localparam int unsigned SEL_W   = (SEQ_LEN > 2) ? $clog2(SEQ_LEN) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      eoc_i,
  input  logic                      auto_mode_i,
  input  logic [NUM_CONV-1:0]       chan_field_i,
  input  logic                      pseudo_diff_i,
  input  logic                      cid_cfg_i,
  input  logic                      fifo_cfg_i,
  output logic [NUM_CONV*SEL_W-1:0] mux_sel_o,
  output logic [NUM_CONV*SEL_W-1:0] tag_o,
  output logic                      cid_en_o,
  output logic                      fifo_avail_o
);

  logic             rst_sync_n;
  chsel_mode_e      mode;
  logic [SEL_W-1:0] seq_val;

  chsel_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  chsel_mode_decode u_decode (
    .auto_mode_i   (auto_mode_i),
    .pseudo_diff_i (pseudo_diff_i),
    .cid_cfg_i     (cid_cfg_i),
    .fifo_cfg_i    (fifo_cfg_i),
    .mode_o        (mode),
    .cid_en_o      (cid_en_o),
    .fifo_avail_o  (fifo_avail_o)
  );

  chsel_pd_sequencer #(.SEQ_LEN(SEQ_LEN)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .eoc_i     (eoc_i),
    .mode_i    (mode),
    .seq_val_o (seq_val)
  );

  for (genvar g = 0; g < NUM_CONV; g++) begin : g_lane
    chsel_lane #(.SEL_W(SEL_W)) u_lane (
      .clk_i     (clk_i),
      .rst_ni    (rst_sync_n),
      .eoc_i     (eoc_i),
      .mode_i    (mode),
      .man_bit_i (chan_field_i[g]),
      .seq_val_i (seq_val),
      .sel_o     (mux_sel_o[g*SEL_W +: SEL_W]),
      .tag_o     (tag_o[g*SEL_W +: SEL_W])
    );
  end

  // R8: pseudo-differential automatic operation forces the channel ID on
  assert_cid_forced_R8: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (auto_mode_i && pseudo_diff_i) |-> cid_en_o);

  // R9: manual mode never offers buffering
  assert_no_fifo_manual_R9: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    !auto_mode_i |-> !fifo_avail_o);

  // R4: the field has no influence under alternation
  assert_alt_ignores_field_R4: assert property (@(posedge clk_i) disable iff (!rst_sync_n)
    (eoc_i && mode == MODE_ALT) |=> (mux_sel_o[SEL_W-1:0] == mux_sel_o[2*SEL_W-1:SEL_W]
                                      || $past(mux_sel_o[SEL_W-1:0]) != $past(mux_sel_o[2*SEL_W-1:SEL_W])));

endmodule

// File: tb/chsel_top_tb.sv
module chsel_top_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       eoc_i;
  logic       auto_mode_i;
  logic [1:0] chan_field_i;
  logic       pseudo_diff_i;
  logic       cid_cfg_i;
  logic       fifo_cfg_i;
  logic [3:0] mux_sel_o;
  logic [3:0] tag_o;
  logic       cid_en_o;
  logic       fifo_avail_o;

  int n_checks = 0;
  int n_fail   = 0;

  // independent expectation state
  int exp_a   = 0;
  int exp_b   = 0;
  int exp_ta  = 0;
  int exp_tb  = 0;
  int exp_ptr = 0;

  always #5 clk_i = ~clk_i;

  chsel_top dut_i (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .eoc_i         (eoc_i),
    .auto_mode_i   (auto_mode_i),
    .chan_field_i  (chan_field_i),
    .pseudo_diff_i (pseudo_diff_i),
    .cid_cfg_i     (cid_cfg_i),
    .fifo_cfg_i    (fifo_cfg_i),
    .mux_sel_o     (mux_sel_o),
    .tag_o         (tag_o),
    .cid_en_o      (cid_en_o),
    .fifo_avail_o  (fifo_avail_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_sel(input string req);
    chk({req, " sel A"}, int'(mux_sel_o[1:0]), exp_a);
    chk({req, " sel B"}, int'(mux_sel_o[3:2]), exp_b);
  endtask

  task automatic chk_tag(input string req);
    chk({req, " tag A"}, int'(tag_o[1:0]), exp_ta);
    chk({req, " tag B"}, int'(tag_o[3:2]), exp_tb);
  endtask

  // Model one pulse from the requirements, apply it, then compare
  task automatic pulse(input string req);
    exp_ta = exp_a;
    exp_tb = exp_b;
    if (!auto_mode_i) begin
      exp_a = int'(chan_field_i[0]);
      exp_b = int'(chan_field_i[1]);
    end else if (!pseudo_diff_i) begin
      exp_a = (exp_a % 2 == 0) ? 1 : 0;
      exp_b = (exp_b % 2 == 0) ? 1 : 0;
    end else begin
      exp_a   = exp_ptr;
      exp_b   = exp_ptr;
      exp_ptr = (exp_ptr + 1) % 4;
    end
    @(negedge clk_i) eoc_i = 1'b1;
    @(negedge clk_i) eoc_i = 1'b0;
    chk_sel(req);
    chk_tag({req, "/R7"});
  endtask

  task automatic t_reset();
    chk_sel("R1");
    chk_tag("R1");
    chk("R8 cid idle", int'(cid_en_o), 0);
    chk("R9 fifo idle", int'(fifo_avail_o), 0);
  endtask

  task automatic t_manual();
    auto_mode_i = 1'b0;
    fifo_cfg_i  = 1'b1;
    @(negedge clk_i);
    chk("R9 manual fifo", int'(fifo_avail_o), 0);
    chan_field_i = 2'b01; pulse("R2 01");
    chan_field_i = 2'b10; pulse("R2 10");
    chan_field_i = 2'b11; pulse("R2 11");
    chan_field_i = 2'b00; pulse("R2 00");
    fifo_cfg_i = 1'b0;
  endtask

  task automatic t_hold();
    chan_field_i = 2'b11; pulse("R2 11b");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i) chan_field_i = 2'(i);
      @(negedge clk_i);
      chk_sel("R3 field change no eoc");
      chk_tag("R10 hold");
    end
  endtask

  task automatic t_alt();
    auto_mode_i   = 1'b1;
    pseudo_diff_i = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chan_field_i = 2'(i + 1);
      pulse("R4 alternate");
    end
  endtask

  task automatic t_seq();
    auto_mode_i   = 1'b1;
    pseudo_diff_i = 1'b1;
    cid_cfg_i     = 1'b0;
    @(negedge clk_i);
    chk("R8 forced", int'(cid_en_o), 1);
    for (int i = 0; i < 6; i++) pulse("R5 sequence");
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk_sel("R10 seq hold");
    end
  endtask

  task automatic t_resume();
    pseudo_diff_i = 1'b0;
    pulse("R6 alt between");
    pulse("R6 alt between");
    auto_mode_i = 1'b0;
    chan_field_i = 2'b10;
    pulse("R6 manual between");
    auto_mode_i   = 1'b1;
    pseudo_diff_i = 1'b1;
    pulse("R6 resume");
    pulse("R6 resume");
    pseudo_diff_i = 1'b0;
    pulse("R4 from seq value");
  endtask

  task automatic t_flags();
    auto_mode_i = 1'b0; pseudo_diff_i = 1'b1; cid_cfg_i = 1'b0; fifo_cfg_i = 1'b1;
    @(negedge clk_i);
    chk("R8 manual pd cid", int'(cid_en_o), 0);
    chk("R9 manual fifo", int'(fifo_avail_o), 0);
    cid_cfg_i = 1'b1;
    @(negedge clk_i);
    chk("R8 cfg passes", int'(cid_en_o), 1);
    auto_mode_i = 1'b1; pseudo_diff_i = 1'b0; cid_cfg_i = 1'b0;
    @(negedge clk_i);
    chk("R8 alt cid", int'(cid_en_o), 0);
    chk("R9 auto fifo on", int'(fifo_avail_o), 1);
    fifo_cfg_i = 1'b0;
    @(negedge clk_i);
    chk("R9 auto fifo off", int'(fifo_avail_o), 0);
  endtask

  initial begin
    rst_ni = 1'b0; eoc_i = 1'b0; auto_mode_i = 1'b0; chan_field_i = 2'b00;
    pseudo_diff_i = 1'b0; cid_cfg_i = 1'b0; fifo_cfg_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_manual();
    t_hold();
    t_alt();
    t_seq();
    t_resume();
    t_flags();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule